// File: doc/BRIEF.md
# Software-Programmed March Test Engine for Embedded RAM

This block is a memory self-test engine that a processor sets up through a small register bus. Software loads a data background, a lower and an upper address bound, and a list of up to eight March elements. It then issues a start command. The engine takes over one RAM port and walks the address window once per element, either ascending or descending. In each cell it applies the element's reads and writes, using either the background or its bit-wise complement. Every read is checked against the value it should return.

When a read does not match, the engine stops at once. It keeps the returned word and the failing address in two capture registers and reports an error state, so the failing cell can be diagnosed. When every element passes, it reports completion. Only while a test is running does a select output hand the RAM port to the engine. At all other times the port stays with the system.

Top module: `mbist_core`

## Requirements
- R1: After reset, every register reads 0, the status flag is idle (0) and `ram_sel` is low.
- R2: Register map on `bus_addr`: 0 background, 1 lower bound, 2 upper bound, 3 index of the last element (0..7), 8+i element slot i. Each of these reads back the value last written to it, truncated to its width. Offset 6 reads the captured data and offset 7 reads the captured address.
- R3: Writing a value with bit 0 set to offset 4 while not busy starts a test. The status flag becomes busy (1) on that clock edge and the element pointer becomes 0.
- R4: Element encoding: bit 0 is the direction (1 = descending) and bits 2:1 hold the operation count minus 1. Operation k uses bit 3+2k (1 = write, 0 = read) and bit 4+2k (1 = complement of background). Per cell the operations run in order. Starting an element costs one cycle, a write costs one cycle and a read costs two. A full run therefore lasts the sum over elements of 1 + cells × (writes + 2 × reads) cycles.
- R5: An ascending element visits lower bound to upper bound and a descending one visits upper to lower. No RAM access falls outside the window.
- R6: On the first read that does not match, the flag becomes error (3), offset 6 holds the returned word, offset 7 holds the cell address, and the test stops.
- R7: When the last element completes without a mismatch, the flag becomes finish (2).
- R8: While busy, bus writes to any register and further start commands have no effect.
- R9: `ram_sel` is high exactly while a test is running, and `ram_en` is never high without it.
- R10: Offset 5 reads the status flag in bits 1:0 and the current element pointer in bits 6:4. After an error, the pointer names the element that failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | BW | Register write data |
| bus_rdata | output | BW | Register read data (combinational from `bus_addr`) |
| ram_sel | output | 1 | RAM port owned by the engine |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after a read strobe |

## Verification
A six-element March program is run fault-free over a sweep of address windows and backgrounds. This separates correct bound handling, element sequencing and exact cycle cost from errors of one element or one address. A stuck-at bit is then injected in turn at every address, at both polarities and with several backgrounds. The expected failing address, the returned word and the failing element differ according to whether the stuck value agrees with the background. A check therefore tells apart a failure caught by a true-data read from one caught by a complement read. Single-element programs in both directions expose the first address visited. A four-operation element exercises the per-cell operation order. Writes issued while busy confirm that the configuration is frozen.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_BUSY = 2'd1,
        FL_FIN  = 2'd2,
        FL_ERR  = 2'd3
    } flag_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_RUN,
        S_CHK
    } seq_st_e;

    localparam int MAX_OPS = 4;
    localparam int ELEM_W  = 3 + 2 * MAX_OPS;

    typedef struct packed {
        logic inv;
        logic wr;
    } op_t;

    typedef struct packed {
        op_t [MAX_OPS-1:0] ops;
        logic [1:0]        cnt_m1;
        logic              down;
    } elem_t;

    localparam logic [2:0] OFS_BG    = 3'd0;
    localparam logic [2:0] OFS_LO    = 3'd1;
    localparam logic [2:0] OFS_HI    = 3'd2;
    localparam logic [2:0] OFS_LAST  = 3'd3;
    localparam logic [2:0] OFS_CMD   = 3'd4;
    localparam logic [2:0] OFS_STAT  = 3'd5;
    localparam logic [2:0] OFS_EDATA = 3'd6;
    localparam logic [2:0] OFS_EADDR = 3'd7;

endpackage

// File: rtl/mbist_addr_ctr.sv
module mbist_addr_ctr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          down,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] addr,
    output logic          at_end
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.addr = down ? hi : lo;
        end else if (step) begin
            ctr_d.addr = down ? AW'(ctr_q.addr - 1'b1) : AW'(ctr_q.addr + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign addr   = ctr_q.addr;
    assign at_end = down ? (ctr_q.addr == lo) : (ctr_q.addr == hi);

    // A step is never requested at the window edge (R5)
    assert_step_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_end);

endmodule

// File: rtl/mbist_datapath.sv
module mbist_datapath #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] bg,
    input  logic          wr_inv,
    input  logic          chk_inv,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wr_pat,
    output logic          mismatch
);

    logic [DW-1:0] exp_pat;

    always_comb begin
        wr_pat   = wr_inv  ? ~bg : bg;
        exp_pat  = chk_inv ? ~bg : bg;
        mismatch = (rdata != exp_pat);
    end

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int NELEM = 8,
    localparam int EPW  = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [EPW-1:0] last,
    input  elem_t          elem,
    input  logic           at_end,
    input  logic           mismatch,
    output logic [EPW-1:0] ptr,
    output flag_e          flag,
    output logic           busy,
    output logic           ctr_load,
    output logic           ctr_step,
    output logic           ctr_down,
    output logic           ram_en,
    output logic           ram_we,
    output logic           wr_inv,
    output logic           chk_inv,
    output logic           log_err
);

    typedef struct packed {
        seq_st_e        st;
        logic [EPW-1:0] ptr;
        logic [1:0]     opi;
        flag_e          flag;
        logic           chk_inv;
    } seq_t;

    seq_t seq_d, seq_q;
    op_t  cur_op;
    logic adv;

    always_comb begin
        seq_d    = seq_q;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        ram_en   = 1'b0;
        ram_we   = 1'b0;
        wr_inv   = 1'b0;
        log_err  = 1'b0;
        adv      = 1'b0;
        cur_op   = elem.ops[seq_q.opi];

        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.st   = S_LOAD;
                    seq_d.ptr  = '0;
                    seq_d.opi  = '0;
                    seq_d.flag = FL_BUSY;
                end
            end
            S_LOAD: begin
                ctr_load = 1'b1;
                seq_d.st = S_RUN;
            end
            S_RUN: begin
                ram_en = 1'b1;
                ram_we = cur_op.wr;
                wr_inv = cur_op.inv;
                if (cur_op.wr) begin
                    adv = 1'b1;
                end else begin
                    seq_d.chk_inv = cur_op.inv;
                    seq_d.st      = S_CHK;
                end
            end
            default: begin
                if (mismatch) begin
                    log_err    = 1'b1;
                    seq_d.flag = FL_ERR;
                    seq_d.st   = S_IDLE;
                end else begin
                    adv = 1'b1;
                end
            end
        endcase

        if (adv) begin
            if (seq_q.opi != elem.cnt_m1) begin
                seq_d.opi = 2'(seq_q.opi + 1'b1);
                seq_d.st  = S_RUN;
            end else begin
                seq_d.opi = '0;
                if (at_end) begin
                    if (seq_q.ptr == last) begin
                        seq_d.flag = FL_FIN;
                        seq_d.st   = S_IDLE;
                    end else begin
                        seq_d.ptr = EPW'(seq_q.ptr + 1'b1);
                        seq_d.st  = S_LOAD;
                    end
                end else begin
                    ctr_step = 1'b1;
                    seq_d.st = S_RUN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, ptr: '0, opi: '0, flag: FL_IDLE, chk_inv: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ptr      = seq_q.ptr;
    assign flag     = seq_q.flag;
    assign busy     = (seq_q.st != S_IDLE);
    assign ctr_down = elem.down;
    assign chk_inv  = seq_q.chk_inv;

    // Leaving the busy state always ends in finish or error (R7)
    assert_exit_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flag == FL_FIN || flag == FL_ERR));

    // An error report is held until the next start (R6)
    assert_err_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == FL_ERR && !start) |=> flag == FL_ERR);

endmodule

// File: rtl/mbist_core.sv
module mbist_core
    import mbist_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int NELEM = 8,
    parameter int BW    = 16,
    localparam int EPW  = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          ram_sel,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);

    typedef struct packed {
        logic [DW-1:0]           bg;
        logic [AW-1:0]           lo;
        logic [AW-1:0]           hi;
        logic [EPW-1:0]          last;
        elem_t [NELEM-1:0]       slots;
        logic [DW-1:0]           edata;
        logic [AW-1:0]           eaddr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic           busy, start, log_err;
    logic [EPW-1:0] ptr;
    flag_e          flag;
    logic           ctr_load, ctr_step, ctr_down, at_end;
    logic           wr_inv, chk_inv, mismatch;
    logic [AW-1:0]  cur_addr;
    logic [EPW-1:0] sidx;
    logic           sidx_ok;
    elem_t          cur_elem;

    assign sidx     = bus_addr[EPW-1:0];
    assign sidx_ok  = (int'(bus_addr[2:0]) < NELEM);
    assign start    = bus_wr && !busy && !bus_addr[3] && (bus_addr[2:0] == OFS_CMD) && bus_wdata[0];
    assign cur_elem = cfg_q.slots[ptr];

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && !busy) begin
            if (bus_addr[3]) begin
                if (sidx_ok) cfg_d.slots[sidx] = elem_t'(bus_wdata[ELEM_W-1:0]);
            end else begin
                case (bus_addr[2:0])
                    OFS_BG:   cfg_d.bg   = bus_wdata[DW-1:0];
                    OFS_LO:   cfg_d.lo   = bus_wdata[AW-1:0];
                    OFS_HI:   cfg_d.hi   = bus_wdata[AW-1:0];
                    OFS_LAST: cfg_d.last = bus_wdata[EPW-1:0];
                    OFS_CMD: begin
                        if (bus_wdata[0]) begin
                            cfg_d.edata = '0;
                            cfg_d.eaddr = '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (log_err) begin
            cfg_d.edata = ram_rdata;
            cfg_d.eaddr = cur_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[3]) begin
            if (sidx_ok) bus_rdata[ELEM_W-1:0] = cfg_q.slots[sidx];
        end else begin
            case (bus_addr[2:0])
                OFS_BG:    bus_rdata[DW-1:0]  = cfg_q.bg;
                OFS_LO:    bus_rdata[AW-1:0]  = cfg_q.lo;
                OFS_HI:    bus_rdata[AW-1:0]  = cfg_q.hi;
                OFS_LAST:  bus_rdata[EPW-1:0] = cfg_q.last;
                OFS_STAT: begin
                    bus_rdata[1:0]     = flag;
                    bus_rdata[4 +: EPW] = ptr;
                end
                OFS_EDATA: bus_rdata[DW-1:0]  = cfg_q.edata;
                OFS_EADDR: bus_rdata[AW-1:0]  = cfg_q.eaddr;
                default: ;
            endcase
        end
    end

    mbist_seq #(.NELEM(NELEM)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last     (cfg_q.last),
        .elem     (cur_elem),
        .at_end   (at_end),
        .mismatch (mismatch),
        .ptr      (ptr),
        .flag     (flag),
        .busy     (busy),
        .ctr_load (ctr_load),
        .ctr_step (ctr_step),
        .ctr_down (ctr_down),
        .ram_en   (ram_en),
        .ram_we   (ram_we),
        .wr_inv   (wr_inv),
        .chk_inv  (chk_inv),
        .log_err  (log_err)
    );

    mbist_addr_ctr #(.AW(AW)) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctr_load),
        .step   (ctr_step),
        .down   (ctr_down),
        .lo     (cfg_q.lo),
        .hi     (cfg_q.hi),
        .addr   (cur_addr),
        .at_end (at_end)
    );

    mbist_datapath #(.DW(DW)) dp_i (
        .bg       (cfg_q.bg),
        .wr_inv   (wr_inv),
        .chk_inv  (chk_inv),
        .rdata    (ram_rdata),
        .wr_pat   (ram_wdata),
        .mismatch (mismatch)
    );

    assign ram_sel  = busy;
    assign ram_addr = cur_addr;

    // RAM strobes only while the port is handed over (R9)
    assert_strobe_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> ram_sel);

    // Every access stays inside the programmed window (R5)
    assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (ram_addr >= cfg_q.lo && ram_addr <= cfg_q.hi));

    // Configuration frozen while a test runs (R8)
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && $past(ram_sel)) |-> ($stable(cfg_q.bg) && $stable(cfg_q.lo) &&
                                         $stable(cfg_q.hi) && $stable(cfg_q.slots)));

endmodule

// File: tb/mbist_core_tb.sv
module mbist_core_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int BW = 16;
    localparam int NC = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic          ram_sel, ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int stray = 0;

    logic [DW-1:0] mem [NC];
    logic          f_en = 1'b0;
    logic [AW-1:0] f_addr = '0;
    int            f_bit = 0;
    logic          f_val = 1'b0;

    always #4 clk = ~clk;

    mbist_core #(.AW(AW), .DW(DW), .NELEM(8), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_sel(ram_sel),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en && !ram_sel) stray <= stray + 1;
        if (ram_sel && ram_en) begin
            if (ram_we) begin
                logic [DW-1:0] v;
                v = ram_wdata;
                if (f_en && ram_addr == f_addr) v[f_bit] = f_val;
                mem[ram_addr] <= v;
            end
            ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [BW-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [BW-1:0] mk(input bit dn, input int n, input logic [3:0] w, input logic [3:0] iv);
        logic [BW-1:0] r;
        r = '0;
        r[0] = dn;
        r[2:1] = 2'(n - 1);
        for (int k = 0; k < 4; k++) begin
            r[3 + 2*k] = w[k];
            r[4 + 2*k] = iv[k];
        end
        return r;
    endfunction

    function automatic int cost(input int cells, input int n, input logic [3:0] w);
        int c;
        c = 0;
        for (int k = 0; k < n; k++) c += w[k] ? 1 : 2;
        return 1 + cells * c;
    endfunction

    // March program: up(w a) up(r a,w a') up(r a',w a) dn(r a,w a') dn(r a',w a) dn(r a)
    bit       pd [6] = '{0, 0, 0, 1, 1, 1};
    int       pn [6] = '{1, 2, 2, 2, 2, 1};
    logic [3:0] pw [6] = '{4'b0001, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0000};
    logic [3:0] pi [6] = '{4'b0000, 4'b0010, 4'b0001, 4'b0010, 4'b0001, 4'b0000};

    task automatic load_march();
        for (int e = 0; e < 6; e++) wr(4'(8 + e), mk(pd[e], pn[e], pw[e], pi[e]));
        wr(4'd3, 16'd5);
    endtask

    task automatic set_cfg(input logic [DW-1:0] bg, input int lo, input int hi);
        wr(4'd0, BW'(bg));
        wr(4'd1, BW'(lo));
        wr(4'd2, BW'(hi));
    endtask

    task automatic run(output int cyc);
        wr(4'd4, 16'd1);
        cyc = 0;
        while (ram_sel && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [BW-1:0] v;
        int cyc, exp_c;
        for (int i = 0; i < NC; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", 32'(v), 32'd0);
        end
        chk("R1 ram_sel after reset", 32'(ram_sel), 32'd0);

        // R2: register readback
        load_march();
        set_cfg(8'hC3, 2, 13);
        for (int e = 0; e < 6; e++) begin
            rd(4'(8 + e), v);
            chk("R2 slot readback", 32'(v), 32'(mk(pd[e], pn[e], pw[e], pi[e])));
        end
        rd(4'd0, v); chk("R2 background", 32'(v), 32'hC3);
        rd(4'd1, v); chk("R2 lower bound", 32'(v), 32'd2);
        rd(4'd2, v); chk("R2 upper bound", 32'(v), 32'd13);
        rd(4'd3, v); chk("R2 last index", 32'(v), 32'd5);

        // R3/R9/R5: start, first access direction
        wr(4'd8, mk(1, 1, 4'b0001, 4'b0000));
        wr(4'd3, 16'd0);
        set_cfg(8'h0F, 3, 12);
        bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 16'd1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'd5, v);
        chk("R3 busy after start", 32'(v[1:0]), 32'd1);
        chk("R3 pointer zero", 32'(v[6:4]), 32'd0);
        chk("R9 select while busy", 32'(ram_sel), 32'd1);
        @(negedge clk);
        chk("R5 descending starts at upper", 32'(ram_addr), 32'd12);
        while (ram_sel) @(negedge clk);
        wr(4'd8, mk(0, 1, 4'b0001, 4'b0000));
        wr(4'd4, 16'd1);
        chk("R5 ascending starts at lower", 32'(ram_addr), 32'd3);
        while (ram_sel) @(negedge clk);
        chk("R9 select released", 32'(ram_sel), 32'd0);

        // R4/R5/R7: fault-free window sweep
        load_march();
        for (int lo = 0; lo < NC; lo += 5) begin
            for (int hi = lo; hi < NC; hi += 4) begin
                logic [DW-1:0] bg;
                bg = 8'(lo * 17 + hi * 3 + 1);
                for (int i = 0; i < NC; i++) mem[i] = bg ^ 8'h5A;
                set_cfg(bg, lo, hi);
                run(cyc);
                exp_c = 0;
                for (int e = 0; e < 6; e++) exp_c += cost(hi - lo + 1, pn[e], pw[e]);
                chk("R4 run cycle count", 32'(cyc), 32'(exp_c));
                rd(4'd5, v);
                chk("R7 finish flag", 32'(v[1:0]), 32'd2);
                for (int i = 0; i < NC; i++)
                    chk("R5 memory contents", 32'(mem[i]), 32'((i >= lo && i <= hi) ? bg : bg ^ 8'h5A));
            end
        end

        // R6/R10: stuck-at sweep over every address
        f_en = 1'b1;
        for (int b = 0; b < 3; b++) begin
            logic [DW-1:0] bg;
            bg = (b == 0) ? 8'h00 : (b == 1) ? 8'hA5 : 8'hFF;
            set_cfg(bg, 0, NC - 1);
            for (int f = 0; f < NC; f++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [DW-1:0] p;
                    bit early;
                    f_addr = 4'(f); f_bit = f % DW; f_val = s[0];
                    early = (bg[f % DW] != s[0]);
                    p = early ? bg : ~bg;
                    p[f % DW] = s[0];
                    run(cyc);
                    rd(4'd5, v);
                    chk("R6 error flag", 32'(v[1:0]), 32'd3);
                    chk("R10 failing element", 32'(v[6:4]), early ? 32'd1 : 32'd2);
                    rd(4'd6, v); chk("R6 captured data", 32'(v), 32'(p));
                    rd(4'd7, v); chk("R6 captured address", 32'(v), 32'(f));
                    if (early && f < NC - 1)
                        chk("R6 stopped at first mismatch", 32'(mem[f + 1]), 32'(bg));
                end
            end
        end

        // R6/R5: fault outside the window is never seen
        f_addr = 4'd2; f_bit = 0; f_val = 1'b1;
        set_cfg(8'h00, 4, 11);
        run(cyc);
        rd(4'd5, v);
        chk("R5 fault outside window ignored", 32'(v[1:0]), 32'd2);
        f_en = 1'b0;

        // R8: writes while busy have no effect
        set_cfg(8'h3C, 0, NC - 1);
        wr(4'd4, 16'd1);
        wr(4'd0, 16'h00FF);
        wr(4'd1, 16'd7);
        wr(4'd8, 16'h0000);
        wr(4'd3, 16'd0);
        wr(4'd4, 16'd1);
        rd(4'd5, v);
        chk("R3 status busy mid-run", 32'(v[1:0]), 32'd1);
        while (ram_sel) @(negedge clk);
        rd(4'd0, v); chk("R8 background kept", 32'(v), 32'h3C);
        rd(4'd1, v); chk("R8 lower bound kept", 32'(v), 32'd0);
        rd(4'd3, v); chk("R8 last index kept", 32'(v), 32'd5);
        rd(4'd8, v); chk("R8 slot kept", 32'(v), 32'(mk(pd[0], pn[0], pw[0], pi[0])));
        rd(4'd5, v); chk("R7 finish after busy writes", 32'(v[1:0]), 32'd2);

        // R4: four-operation element then descending read
        wr(4'd8, mk(0, 4, 4'b0101, 4'b1100));
        wr(4'd9, mk(1, 1, 4'b0000, 4'b0001));
        wr(4'd3, 16'd1);
        set_cfg(8'h96, 5, 10);
        run(cyc);
        chk("R4 four-op cycle count", 32'(cyc), 32'(cost(6, 4, 4'b0101) + cost(6, 1, 4'b0000)));
        rd(4'd5, v); chk("R7 four-op finish", 32'(v[1:0]), 32'd2);
        chk("R4 cell holds complement", 32'(mem[7]), 32'h69);

        chk("R9 no strobe without select", 32'(stray), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule